// File: doc/BRIEF.md
# Static memory bus cycle controller

This block converts internal read and write requests into external bus cycles for static RAM wired directly to the chip. A request carries an address, an access size, a read/write flag, write data and a flag that asks for a 16-byte line transfer. The block returns the read data and a one-cycle completion pulse. On the memory side it drives a start-of-cycle strobe, an active-low chip select, an active-low read strobe, active-low per-byte write enables, the address, the write data and a data drive enable. The bus is either 16 or 32 bits wide, set by a parameter.

Each access beat is made of a first cycle (T1), a parameterised number of wait cycles, and a final cycle (T2). Chip select goes high at the falling clock edge inside T2, so two beats in a row always leave half a cycle with the select high. Single accesses use the size of the request. Line transfers ignore the request size and always move the whole line as full-width beats from the 16-byte-aligned base address, one beat straight after another, with the bus held throughout.

A requester raises `req_valid` for one cycle while the block is idle and then waits for `rsp_done`. Requests raised while a transfer is in progress are dropped.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: Every beat is one T1 cycle, then WAIT_CYC wait cycles, then one T2 cycle. `bus_bs` is high in T1 only, which is exactly one cycle per beat. The first T1 starts in the cycle after the clock edge that accepted the request.
- R2: `bus_cs_n` is low from the start of T1 until the falling clock edge inside T2. It is high for the second half of T2 and high whenever the block is idle.
- R3: On a read, `bus_rd_n` is low through every cycle of every beat and all `bus_we_n` bits stay high. For a single access, `bus_addr` carries the exact request address. Each beat captures the full bus width from `bus_din` at the end of T2. Beat k lands in `rsp_rdata[k*BUS_W +: BUS_W]` and the unused upper bits read as zero.
- R4: A single byte or word write pulls low only the write enables of the bytes it covers. Byte lane i is `bus_dout[8i+7:8i]` and `bus_we_n[i]`. The lane index is the address modulo the bus width in bytes. A word covers the lane pair starting at its even address, and on a 16-bit bus it covers both lanes. Byte data is copied onto every lane and word data onto every lane pair.
- R5: `req_size` uses 0 for byte, 1 for word and 2 for longword. A single longword is one all-lane beat on a 32-bit bus. On a 16-bit bus it is two beats, at the address and at the address plus 2, and the low half of `req_wdata` goes first.
- R6: A line transfer has 16/(BUS_W/8) beats. It starts at the 16-byte-aligned base and the address steps by BUS_W/8 on each beat. T2 of one beat is followed directly by T1 of the next. Beat k writes `req_wdata[k*BUS_W +: BUS_W]` with every write enable low.
- R7: A line transfer uses full-width beats from the aligned base whatever `req_size` and the low address bits are.
- R8: During wait cycles `bus_addr`, `bus_rd_n`, `bus_we_n` and `bus_dout` keep their T1 values.
- R9: `rsp_done` is high for exactly one cycle, in the cycle after the last T2, and `rsp_rdata` holds the result in that cycle.
- R10: A `req_valid` raised while a transfer is in progress is ignored. It adds no beat and does not change the address.
- R11: After reset, `bus_bs`, `rsp_done` and `bus_doe` are 0, and `bus_cs_n`, `bus_rd_n` and all `bus_we_n` bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_write | input | 1 | 1 for a write |
| req_line | input | 1 | 1 for a 16-byte line transfer |
| req_wdata | input | 128 | Write data: low bits for singles, beat k in slice k for lines |
| rsp_rdata | output | 128 | Read data, beat k in slice k |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_bs | output | 1 | Start-of-cycle strobe, high in T1 |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | BUS_W/8 | Per-byte write enables, active low |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | BUS_W | Write data to the memory |
| bus_doe | output | 1 | Data drive enable during writes |
| bus_din | input | BUS_W | Read data from the memory |

## Verification
A fixed-seed random stream mixes byte, word and longword singles with line reads and writes at random addresses. The bench compares every cycle against a slot pattern worked out from the beat count and the wait setting, and it checks the stored bytes against a model memory. This separates the exact-address single path from the aligned full-width line path. It also separates byte-lane selection by address from lane replication. Directed cases start line transfers from byte and word requests at unaligned addresses, place bytes in the top lane, and raise a second request in mid-transfer to show that it is dropped without extra beats.

// File: rtl/sramc_pkg.sv
package sramc_pkg;
  localparam int LINE_BYTES = 16;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int LINE_LSB   = $clog2(LINE_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_TW   = 2'd2,
    PH_T2   = 2'd3
  } phase_e;
endpackage

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int WAIT_CYC = 1,
  parameter int BEAT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BEAT_W-1:0] nbeats,
  output phase_e            phase,
  output logic [BEAT_W-1:0] beat,
  output logic              last_beat
);
  localparam int WW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC + 1) : 1;
  localparam logic [WW-1:0] WLOAD = WW'((WAIT_CYC > 0) ? WAIT_CYC - 1 : 0);

  logic [WW-1:0] wcnt;

  assign last_beat = (beat == nbeats - BEAT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      beat  <= '0;
      wcnt  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_T1;
          beat  <= '0;
        end
        PH_T1: begin
          if (WAIT_CYC == 0) phase <= PH_T2;
          else begin
            phase <= PH_TW;
            wcnt  <= WLOAD;
          end
        end
        PH_TW: begin
          if (wcnt == '0) phase <= PH_T2;
          else wcnt <= wcnt - WW'(1);
        end
        default: begin
          if (last_beat) phase <= PH_IDLE;
          else begin
            beat  <= beat + BEAT_W'(1);
            phase <= PH_T1;
          end
        end
      endcase
    end
  end

  // R6
  beat_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (beat < nbeats));

  // R1
  t1_leaves_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_T1) |=> (phase != PH_T1));
endmodule

// File: rtl/sramc_lane_map.sv
module sramc_lane_map
  import sramc_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic [$clog2(BUS_W/8)-1:0] addr_lo,
  input  logic [1:0]                 size,
  input  logic                       line,
  input  logic [BUS_W-1:0]           wdata_beat,
  input  logic [15:0]                wdata_lo,
  output logic [BUS_W/8-1:0]         mask,
  output logic [BUS_W-1:0]           dout
);
  localparam int NB = BUS_W / 8;
  localparam int LW = $clog2(NB);

  logic          full;
  logic [NB-1:0] word_mask;

  assign full = line || (size >= 2'(SZ_LONG));

  generate
    if (NB == 2) begin : g_narrow
      assign word_mask = '1;
    end else begin : g_wide
      assign word_mask = NB'(3) << (addr_lo[LW-1] ? 2 : 0);
    end
  endgenerate

  always_comb begin
    if (full) begin
      mask = '1;
      dout = wdata_beat;
    end else if (size == 2'(SZ_BYTE)) begin
      mask = NB'(1) << addr_lo;
      dout = {NB{wdata_lo[7:0]}};
    end else begin
      mask = word_mask;
      dout = {(NB/2){wdata_lo}};
    end
  end

  // R4
  mask_nonzero_chk: assert final ($countones(mask) >= 1);
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sramc_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 32,
  parameter int WAIT_CYC = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_write,
  input  logic                req_line,
  input  logic [127:0]        req_wdata,
  output logic [127:0]        rsp_rdata,
  output logic                rsp_done,
  output logic                bus_bs,
  output logic                bus_cs_n,
  output logic                bus_rd_n,
  output logic [BUS_W/8-1:0]  bus_we_n,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [BUS_W-1:0]    bus_dout,
  output logic                bus_doe,
  input  logic [BUS_W-1:0]    bus_din
);
  localparam int NB         = BUS_W / 8;
  localparam int LW         = $clog2(NB);
  localparam int BEAT_W     = 4;
  localparam int LINE_BEATS = LINE_BYTES / NB;

  phase_e              phase;
  logic [BEAT_W-1:0]   beat;
  logic                last_beat;
  logic                start;
  logic [ADDR_W-1:0]   addr_q;
  logic [1:0]          size_q;
  logic                wr_q;
  logic                line_q;
  logic [LINE_W-1:0]   wdata_q;
  logic [BEAT_W-1:0]   nbeats_q;
  logic [LINE_W-1:0]   rdata_q;
  logic                done_q;
  logic                late_q;
  logic                active;
  logic [NB-1:0]       mask;
  logic [BUS_W-1:0]    dout;

  assign start  = req_valid && (phase == PH_IDLE);
  assign active = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      size_q   <= '0;
      wr_q     <= 1'b0;
      line_q   <= 1'b0;
      wdata_q  <= '0;
      nbeats_q <= BEAT_W'(1);
    end else if (start) begin
      addr_q   <= req_line ? {req_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}} : req_addr;
      size_q   <= req_size;
      wr_q     <= req_write;
      line_q   <= req_line;
      wdata_q  <= req_wdata;
      if (req_line) nbeats_q <= BEAT_W'(LINE_BEATS);
      else if (req_size >= 2'(SZ_LONG) && NB == 2) nbeats_q <= BEAT_W'(2);
      else nbeats_q <= BEAT_W'(1);
    end
  end

  sramc_seq #(.WAIT_CYC(WAIT_CYC), .BEAT_W(BEAT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .nbeats    (nbeats_q),
    .phase     (phase),
    .beat      (beat),
    .last_beat (last_beat)
  );

  sramc_lane_map #(.BUS_W(BUS_W)) u_lanes (
    .addr_lo    (addr_q[LW-1:0]),
    .size       (size_q),
    .line       (line_q),
    .wdata_beat (wdata_q[beat*BUS_W +: BUS_W]),
    .wdata_lo   (wdata_q[15:0]),
    .mask       (mask),
    .dout       (dout)
  );

  // read capture at the end of each T2, completion after the final one
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (phase == PH_T2) && last_beat;
      if (start) rdata_q <= '0;
      else if (phase == PH_T2 && !wr_q) rdata_q[beat*BUS_W +: BUS_W] <= bus_din;
    end
  end

  // falling-edge stage that releases chip select in the middle of T2
  always_ff @(negedge clk) begin
    if (rst) late_q <= 1'b0;
    else     late_q <= (phase == PH_T2);
  end

  assign bus_bs    = (phase == PH_T1);
  assign bus_cs_n  = !(active && !(late_q && phase == PH_T2));
  assign bus_rd_n  = !(active && !wr_q);
  assign bus_we_n  = (active && wr_q) ? ~mask : '1;
  assign bus_doe   = active && wr_q;
  assign bus_addr  = addr_q + (ADDR_W'(beat) << LW);
  assign bus_dout  = dout;
  assign rsp_rdata = rdata_q;
  assign rsp_done  = done_q;

  // R1
  bs_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_bs |=> !bus_bs);

  // R2
  cs_with_bs_chk: assert property (@(posedge clk) disable iff (rst)
    bus_bs |-> !bus_cs_n);

  // R3
  read_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> (&bus_we_n));

  // R6
  line_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_doe && line_q) |-> (bus_we_n == '0));

  // R8
  wait_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TW) |-> ($stable(bus_addr) && $stable(bus_we_n)
                          && $stable(bus_rd_n) && $stable(bus_dout)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    active |=> $stable(addr_q));
endmodule

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 32;
  localparam int WAIT  = 1;
  localparam int NB    = BUS_W / 8;
  localparam int LW    = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic          req_line = 1'b0;
  logic [127:0]  req_wdata = '0;
  logic [127:0]  rsp_rdata;
  logic          rsp_done;
  logic          bus_bs, bus_cs_n, bus_rd_n, bus_doe;
  logic [NB-1:0] bus_we_n;
  logic [31:0]   bus_addr;
  logic [BUS_W-1:0] bus_dout, bus_din;

  logic [7:0] dev_mem [256];
  logic [7:0] ref_mem [256];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_cycle_ctrl #(.BUS_W(BUS_W), .ADDR_W(32), .WAIT_CYC(WAIT)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_line(req_line),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .bus_bs(bus_bs), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );

  // memory device model: full-width read, lane writes when select rises
  always_comb begin
    for (int i = 0; i < NB; i++)
      bus_din[8*i +: 8] = dev_mem[8'((bus_addr[7:0] & 8'(~(NB-1))) + i)];
  end

  always @(posedge bus_cs_n) begin
    if (!rst) begin
      for (int i = 0; i < NB; i++)
        if (bus_we_n[i] === 1'b0)
          dev_mem[8'((bus_addr[7:0] & 8'(~(NB-1))) + i)] = bus_dout[8*i +: 8];
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int nbeats_f(input logic [1:0] sz, input bit ln);
    if (ln) return 16 / NB;
    if (sz >= 2 && NB == 2) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] base_f(input logic [31:0] a, input bit ln);
    return ln ? {a[31:4], 4'b0} : a;
  endfunction

  function automatic logic [NB-1:0] mask_f(input logic [31:0] a, input logic [1:0] sz,
                                            input bit ln);
    if (ln || sz >= 2) return '1;
    if (sz == 0) return NB'(1) << a[LW-1:0];
    if (NB == 2) return '1;
    return NB'(3) << (a[LW-1] ? 2 : 0);
  endfunction

  function automatic logic [BUS_W-1:0] dout_f(input logic [127:0] wd, input logic [1:0] sz,
                                               input bit ln, input int b);
    if (ln || sz >= 2) return wd[b*BUS_W +: BUS_W];
    if (sz == 0) return {NB{wd[7:0]}};
    return {(NB/2){wd[15:0]}};
  endfunction

  task automatic ref_apply(input logic [31:0] a, input logic [1:0] sz, input bit ln,
                           input logic [127:0] wd);
    logic [31:0] base = base_f(a, ln);
    for (int b = 0; b < nbeats_f(sz, ln); b++) begin
      logic [NB-1:0] m = mask_f(a, sz, ln);
      logic [BUS_W-1:0] d = dout_f(wd, sz, ln, b);
      logic [7:0] al = 8'((base[7:0] + 8'(b*NB)) & 8'(~(NB-1)));
      for (int i = 0; i < NB; i++)
        if (m[i]) ref_mem[8'(al + i)] = d[8*i +: 8];
    end
  endtask

  task automatic txn(input logic [31:0] a, input logic [1:0] sz, input bit wr,
                     input bit ln, input logic [127:0] wd, input bit poke);
    int nb = nbeats_f(sz, ln);
    int per = WAIT + 2;
    int total = nb * per;
    logic [31:0] base = base_f(a, ln);
    logic [127:0] exp_rd = '0;
    for (int b = 0; b < nb; b++) begin
      logic [7:0] al = 8'((base[7:0] + 8'(b*NB)) & 8'(~(NB-1)));
      for (int i = 0; i < NB; i++) exp_rd[b*BUS_W + 8*i +: 8] = ref_mem[8'(al + i)];
    end
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_line = ln; req_wdata = wd;
    for (int c = 0; c <= total + 1; c++) begin
      int b = c / per;
      int pos = c % per;
      @(posedge clk); #1;
      if (c == 0) req_valid = 1'b0;
      if (poke && c == 1) begin req_valid = 1'b1; req_addr = ~a; end
      if (poke && c == 2) req_valid = 1'b0;
      if (c < total) begin
        chk(bus_bs === (pos == 0), "R1 bs per slot", 128'(bus_bs), 128'(pos == 0));
        chk(bus_cs_n === 1'b0, "R2 cs low first half", 128'(bus_cs_n), 128'(0));
        chk(bus_addr === base + 32'(b*NB), "R3/R6/R7 beat address", 128'(bus_addr),
            128'(base + 32'(b*NB)));
        chk(bus_rd_n === wr, "R3 read strobe", 128'(bus_rd_n), 128'(wr));
        chk(bus_we_n === (wr ? ~mask_f(a, sz, ln) : '1), "R4/R5/R6 write enables",
            128'(bus_we_n), 128'(wr ? ~mask_f(a, sz, ln) : '1));
        if (wr) chk(bus_dout === dout_f(wd, sz, ln, b), "R4/R5/R6/R8 write data",
                    128'(bus_dout), 128'(dout_f(wd, sz, ln, b)));
        chk(rsp_done === 1'b0, "R9 no early done", 128'(rsp_done), 128'(0));
      end else if (c == total) begin
        chk(rsp_done === 1'b1, "R9 done after last T2", 128'(rsp_done), 128'(1));
        chk(bus_cs_n === 1'b1 && bus_bs === 1'b0, "R2 idle after transfer",
            128'({bus_bs, bus_cs_n}), 128'(1));
        if (!wr) chk(rsp_rdata === exp_rd, "R3/R5/R6 read data", rsp_rdata, exp_rd);
      end else begin
        chk(rsp_done === 1'b0, "R9 done single cycle", 128'(rsp_done), 128'(0));
        chk(bus_bs === 1'b0 && bus_cs_n === 1'b1, "R10 no extra beat",
            128'({bus_bs, bus_cs_n}), 128'(1));
      end
      @(negedge clk); #1;
      if (c < total)
        chk(bus_cs_n === (pos == per - 1), "R2 cs release at falling edge of T2",
            128'(bus_cs_n), 128'(pos == per - 1));
    end
    if (wr) ref_apply(a, sz, ln, wd);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog expired, actual=hang expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      dev_mem[i] = 8'($urandom);
      ref_mem[i] = dev_mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R11 reset state
    chk(bus_bs === 1'b0 && rsp_done === 1'b0 && bus_doe === 1'b0, "R11 reset strobes",
        128'({bus_bs, rsp_done, bus_doe}), 128'(0));
    chk(bus_cs_n === 1'b1 && bus_rd_n === 1'b1 && bus_we_n === '1, "R11 reset selects",
        128'({bus_cs_n, bus_rd_n, bus_we_n}), 128'({1'b1, 1'b1, {NB{1'b1}}}));

    // directed corners
    txn(32'h4000_0037, 2'd0, 1'b0, 1'b1, '0, 1'b0);      // R7 line read from byte, odd address
    txn(32'h4000_005A, 2'd1, 1'b1, 1'b1, rnd128(), 1'b0); // R7 line write from word
    txn(32'h4000_0013, 2'd0, 1'b1, 1'b0, 128'hA5, 1'b0);  // R4 top lane byte
    txn(32'h4000_0016, 2'd1, 1'b1, 1'b0, 128'hBEEF, 1'b0); // R4 upper word
    txn(32'h4000_0014, 2'd2, 1'b0, 1'b0, '0, 1'b0);       // R5 longword read
    txn(32'h4000_0020, 2'd2, 1'b1, 1'b0, rnd128(), 1'b1);  // R10 poke during longword
    txn(32'h4000_0040, 2'd0, 1'b0, 1'b1, '0, 1'b1);       // R10 poke during line

    for (int k = 0; k < 300; k++) begin
      logic [1:0] sz = 2'($urandom % 3);
      bit ln = ($urandom % 4) == 0;
      bit wr = $urandom % 2;
      logic [31:0] a = {24'h400000, 8'($urandom)};
      if (!ln && sz == 1) a[0] = 1'b0;
      if (!ln && sz == 2) a[1:0] = 2'b00;
      txn(a, sz, wr, ln, rnd128(), ($urandom % 5) == 0);
    end

    begin
      int mm = 0;
      for (int i = 0; i < 256; i++) if (dev_mem[i] !== ref_mem[i]) mm++;
      chk(mm == 0, "R4/R6 stored bytes match model", 128'(mm), 128'(0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule